// File: doc/BRIEF.md
# Three-Channel Interval Timer with Two Compare Points per Channel

This block holds three independent 32-bit timer channels behind a small register-mapped bus. Each channel has a live counter, a reload value and two compare values, and counts either upward or downward. Counting can follow every bus clock or only the pulses on an external tick input. Software programs all three channels through one shared control word.

Each channel can raise three events: a first-compare hit, a second-compare hit and a wrap. Events are latched in a shared sticky status word. A shared mask word decides which latched events drive the single interrupt line. Software clears a status bit by writing 1 to it.

Each channel runs a two-state machine. `T_STOP` is the reset state and is held while the channel's enable bit is 0. The transition `STOP->RUN` is taken on the clock edge after the enable bit is seen at 1. `T_RUN` is where counting happens. The transition `RUN->STOP` is taken on the clock edge after the enable bit is seen at 0.

Top module: `triple_timer`

## Requirements
- R1: After reset every readable register (counters, reload, compare, control 0x30, status 0x34, mask 0x38) reads 0 and `irq` is low.
- R2: For channel i (0..2) the counter, reload, compare-1 and compare-2 registers sit at byte addresses 16*i + 0x0, 0x4, 0x8 and 0xC, and each reads back the last value written.
- R3: In up mode every count step adds 1 to the counter, and a bus write to the counter takes priority over a step in the same cycle.
- R4: With the source bit at 1, a running channel steps exactly once per clock cycle in which `ext_tick` is high, and never otherwise.
- R5: With the direction bit at 1, every count step subtracts 1 from the counter.
- R6: With the source bit at 0, a running channel steps on every clock cycle.
- R7: A step from the limit (all ones when counting up, zero when counting down) loads the reload value into the counter. When the wrap-enable bit is 1, it also sets the channel's wrap status bit.
- R8: With wrap-enable at 0, a wrap still reloads the counter but leaves the status word unchanged.
- R9: `irq` is high exactly when some status bit is 1 while the mask bit at the same position is 0. A mask bit of 1 hides that event.
- R10: A step whose new counter value equals compare-1 (or compare-2) sets the channel's compare-1 (or compare-2) status bit.
- R11: Writing the status word clears each bit written as 1 and leaves the others. An event arriving in the same cycle wins over the clear.
- R12: With the enable bit at 0, the counter keeps its value whatever `ext_tick` does.
- R13: Control bits for channel i are enable at 3i, source at 3i+1, wrap-enable at 3i+2 and direction at 9+i. Status and mask bits are compare-1 at 3i, compare-2 at 3i+1 and wrap at 3i+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counting clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte address; bits 1:0 must be 0 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, valid in the same cycle |
| ext_tick | input | 1 | External count pulse, one step per high cycle |
| irq | output | 1 | Interrupt, high while any unmasked status bit is set |

## Verification
The bench wraps a channel upward from 0xFFFFFFFE and another downward from zero. It does this once with wrap-enable off and once with it on. A design that forgets to reload, reloads only when the event is enabled, or posts the event to the wrong bit position gives a wrong counter value or a wrong status word. Compare hits are driven onto both compare points in turn, and one bit is then cleared by writing 1. A design whose status bits are not sticky, or whose write clears the whole word, shows a wrong status word. The mask is applied to a set status bit to confirm that it hides the event from `irq`. Ticks are pulsed into a disabled channel, and a held tick input is compared against single pulses, to catch a design that counts while stopped or counts clock edges instead of tick pulses.

// File: rtl/timer_pkg.sv
package timer_pkg;
    localparam int NUM_TMR   = 3;
    localparam int EV_PER    = 3;
    localparam int NUM_EV    = NUM_TMR * EV_PER;
    localparam int DIR_BASE  = 9;
    localparam int CTRL_W    = DIR_BASE + NUM_TMR;

    localparam int EV_M1  = 0;
    localparam int EV_M2  = 1;
    localparam int EV_OVF = 2;

    localparam int CF_EN  = 0;
    localparam int CF_SRC = 1;
    localparam int CF_OVF = 2;

    localparam logic [5:0] W_CTRL = 6'd12;
    localparam logic [5:0] W_STAT = 6'd13;
    localparam logic [5:0] W_MASK = 6'd14;

    typedef enum logic [0:0] {
        T_STOP = 1'b0,
        T_RUN  = 1'b1
    } run_state_t;
endpackage

// File: rtl/timer_channel.sv
module timer_channel
    import timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             ext_src,
    input  logic             ovf_en,
    input  logic             count_down,
    input  logic             ext_tick,
    input  logic [3:0]       wr_sel,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] load_q,
    output logic [CNT_W-1:0] m1_q,
    output logic [CNT_W-1:0] m2_q,
    output logic             ev_m1,
    output logic             ev_m2,
    output logic             ev_ovf
);
    localparam logic [CNT_W-1:0] TOP_VAL = '1;

    run_state_t       state_q, state_d;
    logic             step;
    logic             at_limit;
    logic [CNT_W-1:0] cnt_nxt;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            T_STOP: if (en)  state_d = T_RUN;
            T_RUN:  if (!en) state_d = T_STOP;
            default: state_d = T_STOP;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= T_STOP;
        else        state_q <= state_d;
    end

    always_comb begin
        step     = (state_q == T_RUN) && en && (ext_src ? ext_tick : 1'b1);
        at_limit = count_down ? (cnt_q == '0) : (cnt_q == TOP_VAL);
        if (at_limit)        cnt_nxt = load_q;
        else if (count_down) cnt_nxt = cnt_q - CNT_W'(1);
        else                 cnt_nxt = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            load_q <= '0;
            m1_q   <= '0;
            m2_q   <= '0;
        end else begin
            if (wr_sel[0])  cnt_q <= wdata;
            else if (step)  cnt_q <= cnt_nxt;
            if (wr_sel[1])  load_q <= wdata;
            if (wr_sel[2])  m1_q   <= wdata;
            if (wr_sel[3])  m2_q   <= wdata;
        end
    end

    // event outputs
    always_comb begin
        ev_m1  = step && !wr_sel[0] && (cnt_nxt == m1_q);
        ev_m2  = step && !wr_sel[0] && (cnt_nxt == m2_q);
        ev_ovf = step && !wr_sel[0] && at_limit && ovf_en;
    end

    // R12: a stopped channel holds its count
    a_r12_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == T_STOP && !wr_sel[0]) |=> $stable(cnt_q));

    // R3: an upward step adds one
    a_r3_up_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !count_down && !at_limit && !wr_sel[0])
        |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

    // R7: a wrap loads the reload value
    a_r7_wrap_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (step && at_limit && !wr_sel[0] && !wr_sel[1])
        |=> (cnt_q == $past(load_q)));
endmodule

// File: rtl/timer_irq_ctrl.sv
module timer_irq_ctrl #(
    parameter int N_EV = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_EV-1:0] events,
    input  logic            st_wr,
    input  logic            mask_wr,
    input  logic [N_EV-1:0] wdata,
    output logic [N_EV-1:0] status_q,
    output logic [N_EV-1:0] mask_q,
    output logic            irq
);
    logic [N_EV-1:0] clr_bits;

    always_comb begin
        clr_bits = st_wr ? wdata : '0;
        irq      = |(status_q & ~mask_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
            mask_q   <= '0;
        end else begin
            status_q <= (status_q & ~clr_bits) | events;
            if (mask_wr) mask_q <= wdata;
        end
    end

    // R11: written ones clear when no event competes
    a_r11_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && events == '0) |=> ((status_q & $past(wdata)) == '0));

    // R10: status bits are sticky without a status write
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !st_wr |=> ((status_q & $past(status_q)) == $past(status_q)));

    // R9: a fully masked word keeps irq low
    a_r9_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_q) |-> !irq);
endmodule

// File: rtl/triple_timer.sv
module triple_timer
    import timer_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              ext_tick,
    output logic              irq
);
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;
    logic              aligned;
    logic              tmr_hit;
    logic [1:0]        tidx;
    logic [1:0]        tsub;
    logic [CTRL_W-1:0] ctrl_q;
    logic [NUM_EV-1:0] events;
    logic [NUM_EV-1:0] status_q;
    logic [NUM_EV-1:0] mask_q;

    logic [CNT_W-1:0] cnt_a  [NUM_TMR];
    logic [CNT_W-1:0] load_a [NUM_TMR];
    logic [CNT_W-1:0] m1_a   [NUM_TMR];
    logic [CNT_W-1:0] m2_a   [NUM_TMR];

    always_comb begin
        word    = bus_addr[ADDR_W-1:2];
        aligned = (bus_addr[1:0] == 2'b00);
        tmr_hit = aligned && (word < WORD_W'(NUM_TMR * 4));
        tidx    = word[3:2];
        tsub    = word[1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else if (bus_wr && aligned && word == WORD_W'(W_CTRL))
            ctrl_q <= bus_wdata[CTRL_W-1:0];
    end

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_chan
        logic [3:0] wsel;
        always_comb begin
            wsel = '0;
            if (bus_wr && tmr_hit && tidx == 2'(i))
                wsel[tsub] = 1'b1;
        end

        timer_channel #(.CNT_W(CNT_W)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .en         (ctrl_q[EV_PER*i + CF_EN]),
            .ext_src    (ctrl_q[EV_PER*i + CF_SRC]),
            .ovf_en     (ctrl_q[EV_PER*i + CF_OVF]),
            .count_down (ctrl_q[DIR_BASE + i]),
            .ext_tick   (ext_tick),
            .wr_sel     (wsel),
            .wdata      (bus_wdata[CNT_W-1:0]),
            .cnt_q      (cnt_a[i]),
            .load_q     (load_a[i]),
            .m1_q       (m1_a[i]),
            .m2_q       (m2_a[i]),
            .ev_m1      (events[EV_PER*i + EV_M1]),
            .ev_m2      (events[EV_PER*i + EV_M2]),
            .ev_ovf     (events[EV_PER*i + EV_OVF])
        );
    end

    timer_irq_ctrl #(.N_EV(NUM_EV)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .events   (events),
        .st_wr    (bus_wr && aligned && word == WORD_W'(W_STAT)),
        .mask_wr  (bus_wr && aligned && word == WORD_W'(W_MASK)),
        .wdata    (bus_wdata[NUM_EV-1:0]),
        .status_q (status_q),
        .mask_q   (mask_q),
        .irq      (irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (tmr_hit) begin
            unique case (tsub)
                2'd0: bus_rdata = 32'(cnt_a[tidx]);
                2'd1: bus_rdata = 32'(load_a[tidx]);
                2'd2: bus_rdata = 32'(m1_a[tidx]);
                default: bus_rdata = 32'(m2_a[tidx]);
            endcase
        end else if (aligned && word == WORD_W'(W_CTRL)) begin
            bus_rdata = 32'(ctrl_q);
        end else if (aligned && word == WORD_W'(W_STAT)) begin
            bus_rdata = 32'(status_q);
        end else if (aligned && word == WORD_W'(W_MASK)) begin
            bus_rdata = 32'(mask_q);
        end
    end
endmodule

// File: tb/tb_triple_timer.sv
module tb_triple_timer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ext_tick = 1'b0;
    logic        irq;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    triple_timer dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ext_tick(ext_tick), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); ext_tick = 1'b1;
            @(negedge clk); ext_tick = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(8'h00, d); check("R1 counter0", d, 0);
        rd(8'h24, d); check("R1 reload2", d, 0);
        rd(8'h30, d); check("R1 control", d, 0);
        rd(8'h34, d); check("R1 status", d, 0);
        rd(8'h38, d); check("R1 mask", d, 0);
        check("R1 irq", 32'(irq), 0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        wr(8'h14, 32'hA5A5_0001);
        wr(8'h18, 32'h0000_1234);
        wr(8'h1C, 32'hFFFF_0000);
        wr(8'h10, 32'h0000_0007);
        rd(8'h14, d); check("R2 reload1", d, 32'hA5A5_0001);
        rd(8'h18, d); check("R2 compare1", d, 32'h0000_1234);
        rd(8'h1C, d); check("R2 compare2", d, 32'hFFFF_0000);
        rd(8'h10, d); check("R2 counter1", d, 32'h0000_0007);
    endtask

    task automatic t_up_ext();
        logic [31:0] d;
        wr(8'h00, 32'd10);
        wr(8'h30, 32'h003);
        idle(2);
        ticks(5);
        rd(8'h00, d); check("R3 R4 up by ticks", d, 32'd15);
        idle(4);
        rd(8'h00, d); check("R4 no tick no step", d, 32'd15);
        @(negedge clk); ext_tick = 1'b1;
        idle(3); ext_tick = 1'b0;
        rd(8'h00, d); check("R4 held tick steps each cycle", d, 32'd18);
        wr(8'h30, 32'h0);
    endtask

    task automatic t_down();
        logic [31:0] d;
        wr(8'h10, 32'd10);
        wr(8'h30, 32'h418);
        idle(2);
        ticks(3);
        rd(8'h10, d); check("R5 down count", d, 32'd7);
        wr(8'h30, 32'h0);
    endtask

    task automatic t_clk_src();
        logic [31:0] a, b;
        wr(8'h00, 32'd100);
        wr(8'h30, 32'h001);
        idle(3);
        rd(8'h00, a);
        rd(8'h00, b);
        check("R6 one step per clock", b - a, 32'd1);
        wr(8'h30, 32'h0);
    endtask

    task automatic t_ovf_up();
        logic [31:0] d;
        wr(8'h34, 32'h1FF);
        wr(8'h04, 32'd100);
        wr(8'h00, 32'hFFFF_FFFE);
        wr(8'h30, 32'h007);
        idle(2);
        ticks(1);
        rd(8'h00, d); check("R7 reach limit", d, 32'hFFFF_FFFF);
        rd(8'h34, d); check("R7 no event before wrap", d, 0);
        ticks(1);
        rd(8'h00, d); check("R7 reload on wrap", d, 32'd100);
        rd(8'h34, d); check("R7 R13 wrap bit ch0", d, 32'h004);
        check("R9 irq unmasked", 32'(irq), 1);
        wr(8'h30, 32'h0);
    endtask

    task automatic t_ovf_down();
        logic [31:0] d;
        wr(8'h34, 32'h1FF);
        wr(8'h24, 32'd50);
        wr(8'h20, 32'd0);
        wr(8'h30, 32'h8C0);
        idle(2);
        ticks(1);
        rd(8'h20, d); check("R8 reload without event", d, 32'd50);
        rd(8'h34, d); check("R8 status untouched", d, 0);
        check("R8 irq low", 32'(irq), 0);
        wr(8'h20, 32'd0);
        wr(8'h30, 32'h9C0);
        idle(1);
        ticks(1);
        rd(8'h34, d); check("R13 wrap bit ch2", d, 32'h100);
        wr(8'h30, 32'h0);
        wr(8'h34, 32'h1FF);
    endtask

    task automatic t_match_clear();
        logic [31:0] d;
        wr(8'h18, 32'd20);
        wr(8'h1C, 32'd22);
        wr(8'h10, 32'd18);
        wr(8'h30, 32'h018);
        idle(2);
        ticks(2);
        rd(8'h34, d); check("R10 compare1 hit ch1", d, 32'h008);
        ticks(2);
        rd(8'h34, d); check("R10 compare2 hit ch1", d, 32'h018);
        wr(8'h30, 32'h0);
        wr(8'h34, 32'h008);
        rd(8'h34, d); check("R11 clear one bit", d, 32'h010);
        wr(8'h38, 32'h010);
        check("R9 masked hides", 32'(irq), 0);
        wr(8'h38, 32'h000);
        check("R9 unmasked shows", 32'(irq), 1);
        wr(8'h34, 32'h010);
        rd(8'h34, d); check("R11 clear last bit", d, 0);
        check("R9 irq drops", 32'(irq), 0);
    endtask

    task automatic t_disabled();
        logic [31:0] d;
        wr(8'h10, 32'd5);
        wr(8'h30, 32'h010);
        idle(2);
        ticks(4);
        rd(8'h10, d); check("R12 disabled holds", d, 32'd5);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_up_ext();
        t_down();
        t_clk_src();
        t_ovf_up();
        t_ovf_down();
        t_match_clear();
        t_disabled();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule